// File: doc/BRIEF.md
# Video Frame Right/Bottom Padder

This block sits in a pixel stream between a layer source and a downstream mixer. It takes an input frame of programmed width and height and sends out a larger frame. A programmed number of fill columns follows each input line, and a programmed number of fill lines follows the last input line. Every inserted pixel carries one programmed 10-bit-per-channel RGB colour. The usual job is to make line widths even, or a multiple of four, for a mixer that needs that alignment. A typical case is one extra column on an odd-width layer.

Pixels are 30 bits wide: red in bits 29:20, green in 19:10 and blue in 9:0. Both pixel ports use valid/ready. A beat moves on a clock edge where valid and ready are both high. The source must hold valid and its data until the beat is accepted. In padding mode the block obeys the downstream ready and never drops a pixel. In the input phase `in_ready` follows `out_ready`. While fill pixels are going out, `in_ready` is low and the input waits. In padding mode the output start-of-frame and end-of-line markers come from the programmed geometry, and the input markers are not used. A frame starts with the first input pixel accepted while the block is idle. A bypass mode passes the stream through untouched.

Top module: `frame_padder`

## Requirements
- R1: After reset, every register reads zero, and both `out_valid` and `in_ready` are low.
- R2: Register map:
  - 0x00 control: bit 0 is bypass, bit 1 is enable.
  - 0x04 picture size: width in bits 15:0, height in bits 31:16.
  - 0x08 right pad: 13-bit column count.
  - 0x0C bottom pad: 13-bit line count.
  - 0x10 fill colour: red in bits 31:22, green in 21:12, blue in 11:2.
  - Unused bits, including colour bits 1:0, read as zero.
- R3: While enable is 0, `out_valid` and `in_ready` stay low and input is ignored. Clearing enable during a frame abandons that frame. The next accepted pixel then starts a new frame.
- R4: With enable 1 and the bypass bit set, each input beat appears unchanged at the output with its markers. `in_ready` equals `out_ready`.
- R5: With enable 1, size, both pad counts and colour all zero give bypass behaviour even when the bypass bit is 0.
- R6: In padding mode each output line holds `width` input pixels followed by `right` fill pixels. Start-of-frame is set on the first pixel of the frame. End-of-line is set on the last pixel of every line.
- R7: In padding mode, `bottom` lines of `width + right` fill pixels follow the `height` input lines.
- R8: While a fill pixel is pending, `out_valid` is high and `in_ready` is low. A fill pixel stalled by `out_ready` low keeps its value.
- R9: Every accepted input pixel leaves in the same cycle. In the input phase `in_ready` equals `out_ready`.
- R10: Register writes made during a frame take effect only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 30 | Input pixel, RGB 10:10:10 |
| in_sof | input | 1 | Input start-of-frame marker |
| in_eol | input | 1 | Input end-of-line marker |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 30 | Output pixel, RGB 10:10:10 |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eol | output | 1 | Output end-of-line marker |

## Verification
The padding path is run with several geometries:
- both pads non-zero;
- a right pad with no bottom pad;
- a one-pixel frame with a single fill line, where every line is one pixel long.

Together they separate the line-length and line-count decisions and catch an off-by-one at either limit. The input gap and downstream ready patterns change between frames, so the fill stall and the pass-through stall are both seen under back-pressure. The bypass path is run once with the bypass bit on real geometry and once with all-zero registers. The shadowing rule is shown by rewriting the geometry in the middle of a frame. The stop rule is shown by clearing enable in the middle of a frame and then running a clean frame after it.

// File: rtl/pad_pkg.sv
package pad_pkg;
  parameter int DIM_W  = 16;
  parameter int PAD_W  = 13;
  parameter int CH_W   = 10;
  parameter int ADDR_W = 5;
  parameter int DATA_W = 32;
  localparam int PIX_W = 3 * CH_W;
  localparam int LEN_W = DIM_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_RIGHT = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_BOT   = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_FILL  = ADDR_W'(5'h10);

  typedef struct packed {
    logic [DIM_W-1:0] width;
    logic [DIM_W-1:0] height;
    logic [PAD_W-1:0] right;
    logic [PAD_W-1:0] bottom;
    logic [PIX_W-1:0] fill;
    logic             bypass;
  } pad_cfg_t;
endpackage

// File: rtl/pad_regfile.sv
module pad_regfile
  import pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              enable,
  output pad_cfg_t          cfg_live
);
  localparam int FILL_LSB = DATA_W - PIX_W;

  logic [1:0]       ctrl_q;
  logic [DIM_W-1:0] width_q, height_q;
  logic [PAD_W-1:0] right_q, bot_q;
  logic [PIX_W-1:0] fill_q;
  logic             all_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
      right_q  <= '0;
      bot_q    <= '0;
      fill_q   <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL:  ctrl_q <= wdata[1:0];
        A_SIZE: begin
          width_q  <= wdata[DIM_W-1:0];
          height_q <= wdata[2*DIM_W-1:DIM_W];
        end
        A_RIGHT: right_q <= wdata[PAD_W-1:0];
        A_BOT:   bot_q   <= wdata[PAD_W-1:0];
        A_FILL:  fill_q  <= wdata[DATA_W-1:FILL_LSB];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DATA_W'(ctrl_q);
      A_SIZE:  rdata = {height_q, width_q};
      A_RIGHT: rdata = DATA_W'(right_q);
      A_BOT:   rdata = DATA_W'(bot_q);
      A_FILL:  rdata = {fill_q, {FILL_LSB{1'b0}}};
      default: rdata = '0;
    endcase
  end

  assign all_zero = (width_q == '0) && (height_q == '0) && (right_q == '0) &&
                    (bot_q == '0) && (fill_q == '0);
  assign enable   = ctrl_q[1];

  assign cfg_live.width  = width_q;
  assign cfg_live.height = height_q;
  assign cfg_live.right  = right_q;
  assign cfg_live.bottom = bot_q;
  assign cfg_live.fill   = fill_q;
  assign cfg_live.bypass = ctrl_q[0] | all_zero;
endmodule

// File: rtl/pad_walker.sv
module pad_walker
  import pad_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     advance,
  input  pad_cfg_t cfg_live,
  output pad_cfg_t cfg_act,
  output logic     busy,
  output logic     in_fill,
  output logic     last_col
);
  logic [LEN_W-1:0] col_q, row_q, line_len, frame_rows;
  logic             last_row;
  pad_cfg_t         shadow_q;

  assign cfg_act    = busy ? shadow_q : cfg_live;
  assign line_len   = LEN_W'(cfg_act.width) + LEN_W'(cfg_act.right);
  assign frame_rows = LEN_W'(cfg_act.height) + LEN_W'(cfg_act.bottom);
  assign last_col   = (col_q == line_len - LEN_W'(1));
  assign last_row   = (row_q == frame_rows - LEN_W'(1));
  assign in_fill    = busy && ((row_q >= LEN_W'(cfg_act.height)) ||
                               (col_q >= LEN_W'(cfg_act.width)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
      shadow_q <= '0;
    end else if (!enable) begin
      busy  <= 1'b0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      if (!busy) shadow_q <= cfg_live;
      if (advance) begin
        if (last_col) begin
          col_q <= '0;
          if (last_row) begin
            row_q <= '0;
            busy  <= 1'b0;
          end else begin
            row_q <= row_q + LEN_W'(1);
            busy  <= 1'b1;
          end
        end else begin
          col_q <= col_q + LEN_W'(1);
          busy  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_padder.sv
module frame_padder
  import pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_data,
  input  logic              in_sof,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_data,
  output logic              out_sof,
  output logic              out_eol
);
  pad_cfg_t cfg_live, cfg_act;
  logic     enable, busy, in_fill, last_col, byp, advance;

  pad_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .enable(enable), .cfg_live(cfg_live)
  );

  pad_walker u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .advance(advance),
    .cfg_live(cfg_live), .cfg_act(cfg_act), .busy(busy),
    .in_fill(in_fill), .last_col(last_col)
  );

  assign byp     = cfg_act.bypass;
  assign advance = enable && !byp && out_valid && out_ready;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    out_sof   = in_sof;
    out_eol   = in_eol;
    if (enable) begin
      if (byp) begin
        in_ready  = out_ready;
        out_valid = in_valid;
      end else begin
        out_sof = !busy;
        out_eol = last_col;
        if (in_fill) begin
          out_valid = 1'b1;
          out_data  = cfg_act.fill;
        end else begin
          in_ready  = out_ready;
          out_valid = in_valid;
        end
      end
    end
  end
endmodule

// File: rtl/frame_padder_chk.sv
module frame_padder_chk
  import pad_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             byp,
  input logic             busy,
  input logic [PIX_W-1:0] fill_act,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sof,
  input logic             out_eol
);
  logic last_eol;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) last_eol <= 1'b1;
    else if (out_valid && out_ready) last_eol <= out_eol;
  end

  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!out_valid && !in_ready));

  p_sof_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !byp && out_valid && out_ready && out_sof) |-> last_eol);

  p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_valid && !in_ready && !out_ready) |=>
      (!enable || (out_valid && $stable(out_data))));

  p_no_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready));

  p_frozen_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fill_act));
endmodule

bind frame_padder frame_padder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .byp(byp), .busy(busy),
  .fill_act(cfg_act.fill), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/frame_padder_bench.sv
module frame_padder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eol = 1'b0;
  logic [29:0] in_data = '0;
  logic        out_valid, out_ready = 1'b0, out_sof, out_eol;
  logic [29:0] out_data;

  typedef struct packed {
    logic        fill;
    logic        bot;
    logic [29:0] data;
    logic        sof;
    logic        eol;
  } ent_t;

  ent_t  src_q[$];
  ent_t  exp_q[$];
  int    checks = 0, errors = 0, cyc = 0, pix_n = 0;
  int    vmode = 0, rmode = 0;
  bit    hs_in = 0, stopped = 0;
  string cur_tag = "R6";

  frame_padder u_frame_padder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit pat(int mode, int n);
    case (mode)
      0: return 1'b1;
      1: return n[0];
      default: return ((n * 7) % 5) != 0;
    endcase
  endfunction

  task automatic cycle();
    ent_t e;
    @(posedge clk); #1;
    cyc++;
    if (hs_in && src_q.size() > 0) void'(src_q.pop_front());
    reg_we = 1'b0;
    if (stopped) begin
      in_valid = 1'b1;
      in_data  = 30'h2AAAAAAA;
    end else if (!(in_valid && !hs_in && src_q.size() > 0)) begin
      in_valid = (src_q.size() > 0) && pat(vmode, cyc);
    end
    if (!stopped && src_q.size() > 0) begin
      in_data = src_q[0].data;
      in_sof  = src_q[0].sof;
      in_eol  = src_q[0].eol;
    end
    out_ready = pat(rmode, cyc + 3);
    #3;
    if (stopped) begin
      chk(!out_valid && !in_ready, "R3", {30'b0, out_valid, in_ready}, 32'h0);
    end else if (exp_q.size() > 0) begin
      e = exp_q[0];
      if (e.fill) begin
        chk(out_valid, "R8", 32'(out_valid), 32'h1);
        chk(!in_ready, "R8", 32'(in_ready), 32'h0);
      end else begin
        chk(out_valid == in_valid, "R9", 32'(out_valid), 32'(in_valid));
        chk(in_ready == out_ready, "R9", 32'(in_ready), 32'(out_ready));
      end
      if (out_valid && out_ready) begin
        chk({out_data, out_sof, out_eol} == {e.data, e.sof, e.eol},
            e.bot ? "R7" : cur_tag,
            {out_data, out_sof, out_eol}, {e.data, e.sof, e.eol});
        void'(exp_q.pop_front());
      end
    end else begin
      chk(!out_valid, "R6", 32'(out_valid), 32'h0);
    end
    hs_in = in_valid && in_ready;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic send_frame(int w, int h, int r, int b, logic [31:0] colour, bit bypass);
    ent_t e;
    for (int row = 0; row < (bypass ? h : h + b); row++) begin
      for (int col = 0; col < (bypass ? w : w + r); col++) begin
        e.sof = (row == 0) && (col == 0);
        e.bot = (row >= h);
        if (row < h && col < w) begin
          pix_n++;
          e.fill = 1'b0;
          e.data = 30'(pix_n * 40503 + 977);
          e.eol  = (col == w - 1);
          src_q.push_back(e);
        end else begin
          e.fill = 1'b1;
          e.data = colour[31:2];
        end
        e.eol = bypass ? (col == w - 1) : (col == w + r - 1);
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0 || src_q.size() > 0) cycle();
    repeat (3) cycle();
  endtask

  task automatic set_geom(int w, int h, int r, int b, logic [31:0] colour);
    wr(5'h04, {16'(h), 16'(w)});
    wr(5'h08, 32'(r));
    wr(5'h0C, 32'(b));
    wr(5'h10, colour);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cycle();
    // R1: reset state
    chk(!out_valid && !in_ready, "R1", {30'b0, out_valid, in_ready}, 32'h0);
    rd(5'h00, 32'h0, "R1"); rd(5'h04, 32'h0, "R1"); rd(5'h08, 32'h0, "R1");
    rd(5'h0C, 32'h0, "R1"); rd(5'h10, 32'h0, "R1");

    // R2: field layout and width masking
    wr(5'h04, 32'h0003_0005);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0000_2001);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0003_0005, "R2"); rd(5'h08, 32'h0000_1FFF, "R2");
    rd(5'h0C, 32'h0000_0001, "R2"); rd(5'h10, 32'hFFFF_FFFC, "R2");
    rd(5'h14, 32'h0, "R2");
    set_geom(0, 0, 0, 0, 32'h0);

    // R5: all-zero registers act as bypass
    wr(5'h00, 32'h2);
    rd(5'h00, 32'h2, "R2");
    cur_tag = "R5";
    send_frame(3, 2, 0, 0, 32'h0, 1'b1);
    drain();

    // R4: bypass bit with real geometry
    set_geom(3, 2, 1, 1, 32'h1234_5678);
    wr(5'h00, 32'h3);
    cur_tag = "R4"; vmode = 1; rmode = 2;
    send_frame(4, 2, 0, 0, 32'h0, 1'b1);
    drain();

    // R6/R7/R8: right and bottom padding
    wr(5'h00, 32'h2);
    set_geom(3, 2, 1, 2, 32'hABCD_EF04);
    cur_tag = "R6"; vmode = 0; rmode = 1;
    send_frame(3, 2, 1, 2, 32'hABCD_EF04, 1'b0);
    drain();

    set_geom(5, 3, 3, 0, 32'h5555_AAA8);
    vmode = 2; rmode = 0;
    send_frame(5, 3, 3, 0, 32'h5555_AAA8, 1'b0);
    drain();

    set_geom(1, 1, 0, 1, 32'hFFC0_0000);
    vmode = 1; rmode = 2;
    send_frame(1, 1, 0, 1, 32'hFFC0_0000, 1'b0);
    drain();

    // R10: geometry rewritten during a frame applies to the next
    set_geom(3, 2, 1, 1, 32'h0F0F_0F0C);
    vmode = 0; rmode = 0; cur_tag = "R10";
    send_frame(3, 2, 1, 1, 32'h0F0F_0F0C, 1'b0);
    send_frame(2, 1, 2, 0, 32'hC0C0_C0C0, 1'b0);
    while (exp_q.size() > 14) cycle();
    set_geom(2, 1, 2, 0, 32'hC0C0_C0C0);
    drain();

    // R3: stop during a frame, then a clean frame
    set_geom(4, 3, 2, 1, 32'h3333_3330);
    cur_tag = "R3"; rmode = 1;
    send_frame(4, 3, 2, 1, 32'h3333_3330, 1'b0);
    repeat (7) cycle();
    src_q.delete(); exp_q.delete();
    stopped = 1;
    wr(5'h00, 32'h0);
    repeat (6) cycle();
    stopped = 0;
    in_valid = 1'b0;
    wr(5'h00, 32'h2);
    send_frame(4, 3, 2, 1, 32'h3333_3330, 1'b0);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule